// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C bus slave that presents a small on-chip byte array as a serial EEPROM. It samples SCL and SDA with the system clock and drives SDA only through an open-drain enable: when the enable is high, the pad pulls the line low. Three strap inputs give the chip address, and a write-control input can protect the whole array.

A parameter selects one of five densities, from 128 to 2048 bytes. The density decides how bits b3..b1 of the select byte are used. Each of those bits is either compared with a strap or taken as a high address bit. An internal address counter supports several kinds of access: reads from the current address, random reads set by a dummy write, sequential reads, and byte or page writes.

Write data is collected in a 16-byte page buffer. The bytes reach the array only after the STOP that ends the write. That STOP starts a programming period of a fixed number of system clocks, and the block ignores the bus for the whole period.

Top module: `i2c_mem_slave`

## Requirements
- R1: The select byte is received MSB first. It is accepted only when bits 7..4 equal 4'b1010 and the density's strap bits match. Bit 0 selects the direction (1 = read, 0 = write). A select byte that is not accepted gets no ACK, and the block then waits for the next START.
- R2: The straps are compared as follows. Bit 1 goes with strap_i[0], bit 2 with strap_i[1] and bit 3 with strap_i[2]. With DENSITY=0 or 1, all three bits are compared. With DENSITY=2, bit 1 is address bit 8 and bits 3..2 are compared. With DENSITY=3, bits 2..1 are address bits 9..8. With DENSITY=4, bits 3..1 are address bits 10..8 and no strap is compared.
- R3: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Bits clocked without a preceding START are not acknowledged.
- R4: The block acknowledges by pulling SDA low through the whole ninth clock. It does this for an accepted select byte, for the address byte and for each accepted write data byte. It releases SDA after the ninth falling edge of SCL, and its enable rises only while SCL is low.
- R5: While wc_i is high, the select and address bytes are still acknowledged. Write data bytes are not acknowledged and leave the array unchanged. wc_i must be tied low when the pin is unused, which enables writes.
- R6: A STOP that ends a write after at least one accepted data byte starts a programming period of PROG_CYCLES clocks. During that period, START, STOP and select bytes are ignored and SDA is never driven.
- R7: A read drives each byte MSB first, then advances the address counter. An ACK from the master continues with the next byte. A NoAck releases the bus and makes the block wait for START. The counter wraps from the last byte of the array to 0.
- R8: A random read works as follows. A write select and an address byte set the counter. A repeated START with a read select then returns the byte at that address.
- R9: A read select sent straight after START returns the byte at the current value of the address counter.
- R10: Page write: each accepted data byte goes into the page buffer and advances only the low 4 counter bits, so the address wraps inside its 16-byte page. A later byte overwrites an earlier byte at the same slot. Only the slots that were received are written to the array.
- R11: After reset, SDA is released, the address counter is 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Chip address straps |
| wc_i | input | 1 | Write control, high protects the array |
| sda_oe_o | output | 1 | Open-drain SDA pull-low enable |

## Verification
The assertions assume that SCL and SDA change well apart in system-clock terms. SDA may change only while SCL is low, except for START and STOP. Each SCL phase must last longer than the synchroniser and edge-detect delay, so that an ACK enable raised after a falling edge is seen while SCL is still low. The bench keeps to these conditions. Its bit period is sixteen system clocks: master data changes four clocks into the low phase, and the master samples four clocks into the high phase. START and STOP are only issued with SCL held high for eight clocks on each side of the SDA change.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK,
        S_BUSY
    } state_e;

    localparam int PAGE_BYTES = 16;
    localparam int PAGE_AW    = 4;
    localparam int BYTE_W     = 8;

    // Select bits b3..b1 (index 2..0) that carry address bits for a density
    function automatic logic [2:0] hi_mask(input int density);
        case (density)
            2:       return 3'b001;
            3:       return 3'b011;
            4:       return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_sh_q[STAGES-1];
            sda_p_q  <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_s    = scl_sh_q[STAGES-1];
    assign sda_s    = sda_sh_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start_ev = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_ev  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2c_mem_devsel.sv
module i2c_mem_devsel
    import i2c_mem_pkg::*;
#(
    parameter int DENSITY = 2
) (
    input  logic [7:0] sel_byte,
    input  logic [2:0] strap,
    output logic       match,
    output logic       rd,
    output logic [2:0] hi_addr
);
    localparam logic [2:0] HI_MASK = hi_mask(DENSITY);

    logic [2:0] bit_ok;

    for (genvar k = 0; k < 3; k++) begin : g_sel
        if (HI_MASK[k]) begin : g_addr
            assign bit_ok[k]  = 1'b1;
            assign hi_addr[k] = sel_byte[k+1];
        end else begin : g_strap
            assign bit_ok[k]  = (sel_byte[k+1] == strap[k]);
            assign hi_addr[k] = 1'b0;
        end
    end

    assign match = (sel_byte[7:4] == 4'b1010) && (&bit_ok);
    assign rd    = sel_byte[0];
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int DENSITY     = 2,
    parameter int PROG_CYCLES = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wc_i,
    output logic       sda_oe_o
);
    localparam int AW   = 7 + DENSITY;
    localparam int PCW  = $clog2(PROG_CYCLES + 1);
    localparam int FULL = 11;

    typedef struct packed {
        state_e                         state;
        logic [BYTE_W-1:0]              shreg;
        logic [3:0]                     bitcnt;
        logic                           oe;
        logic                           rd;
        logic                           mack;
        logic [2:0]                     hi;
        logic [AW-1:0]                  addr;
        logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf;
        logic [PAGE_BYTES-1:0]          pvalid;
        logic [PCW-1:0]                 pcnt;
    } regs_t;

    regs_t q, n;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              sel_match, sel_rd;
    logic [2:0]        sel_hi;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [BYTE_W-1:0] mem_wdata, mem_rdata;
    logic [FULL-1:0]   full_addr;
    logic [PAGE_AW-1:0] slot;
    logic              busy_w;

    i2c_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_mem_devsel #(.DENSITY(DENSITY)) u_devsel (
        .sel_byte (q.shreg),
        .strap    (strap_i),
        .match    (sel_match),
        .rd       (sel_rd),
        .hi_addr  (sel_hi)
    );

    i2c_mem_array #(.AW(AW), .DW(BYTE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (q.addr),
        .rdata (mem_rdata)
    );

    assign full_addr = {q.hi, q.shreg};
    assign slot      = q.addr[PAGE_AW-1:0];
    assign busy_w    = (q.state == S_BUSY);

    always_comb begin
        n         = q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;

        if (q.state == S_BUSY) begin
            // commit one buffer slot per clock during the first 16 cycles
            if (q.pcnt < PCW'(PAGE_BYTES)) begin
                if (q.pvalid[q.pcnt[PAGE_AW-1:0]]) begin
                    mem_we    = 1'b1;
                    mem_waddr = {q.addr[AW-1:PAGE_AW], q.pcnt[PAGE_AW-1:0]};
                    mem_wdata = q.pbuf[q.pcnt[PAGE_AW-1:0]];
                end
            end
            if (q.pcnt == PCW'(PROG_CYCLES - 1)) begin
                n.state  = S_IDLE;
                n.pvalid = '0;
                n.pcnt   = '0;
            end else begin
                n.pcnt = q.pcnt + 1'b1;
            end
        end else if (start_ev) begin
            n.state  = S_DEV;
            n.bitcnt = '0;
            n.oe     = 1'b0;
            n.pvalid = '0;
        end else if (stop_ev) begin
            n.oe     = 1'b0;
            n.bitcnt = '0;
            if ((q.state == S_WR || q.state == S_WR_ACK) && (|q.pvalid)) begin
                n.state = S_BUSY;
                n.pcnt  = '0;
            end else begin
                n.state  = S_IDLE;
                n.pvalid = '0;
            end
        end else begin
            case (q.state)
                S_DEV, S_ADDR, S_WR: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        n.shreg  = {q.shreg[BYTE_W-2:0], sda_s};
                        n.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        n.bitcnt = '0;
                        if (q.state == S_DEV) begin
                            if (sel_match) begin
                                n.oe    = 1'b1;
                                n.rd    = sel_rd;
                                n.hi    = sel_hi;
                                n.state = S_DEV_ACK;
                            end else begin
                                n.state = S_IDLE;
                            end
                        end else if (q.state == S_ADDR) begin
                            n.addr  = full_addr[AW-1:0];
                            n.oe    = 1'b1;
                            n.state = S_ADDR_ACK;
                        end else begin
                            if (!wc_i) begin
                                n.pbuf[slot]   = q.shreg;
                                n.pvalid[slot] = 1'b1;
                                n.addr[PAGE_AW-1:0] = slot + 1'b1;
                                n.oe = 1'b1;
                            end
                            n.state = S_WR_ACK;
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        if (q.rd) begin
                            n.shreg  = mem_rdata;
                            n.oe     = ~mem_rdata[BYTE_W-1];
                            n.bitcnt = 4'd1;
                            n.state  = S_RD;
                        end else begin
                            n.oe     = 1'b0;
                            n.bitcnt = '0;
                            n.state  = S_ADDR;
                        end
                    end
                end
                S_ADDR_ACK, S_WR_ACK: begin
                    if (scl_fall) begin
                        n.oe     = 1'b0;
                        n.bitcnt = '0;
                        n.state  = S_WR;
                    end
                end
                S_RD: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            n.oe    = 1'b0;
                            n.addr  = q.addr + 1'b1;
                            n.state = S_RD_ACK;
                        end else begin
                            n.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                            n.oe     = ~q.shreg[BYTE_W-2];
                            n.bitcnt = q.bitcnt + 1'b1;
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            n.shreg  = mem_rdata;
                            n.oe     = ~mem_rdata[BYTE_W-1];
                            n.bitcnt = 4'd1;
                            n.state  = S_RD;
                        end else begin
                            n.oe    = 1'b0;
                            n.state = S_IDLE;
                        end
                    end
                end
                default: begin
                    n.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o = q.oe;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
    parameter int PROG_CYCLES = 4000,
    parameter int PCW         = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_i,
    input logic           sda_oe_o,
    input logic           busy,
    input logic           mem_we,
    input logic [PCW-1:0] pcnt
);
    // R6: no drive on the bus while programming
    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe_o);

    // R4: pull-low enable only rises while SCL is low
    p_ack_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R10: the array is only written during the programming period
    p_write_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6: programming counter stays inside its window
    p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pcnt < PCW'(PROG_CYCLES)));

    // R6: the period ends at its last count
    p_busy_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pcnt == PCW'(PROG_CYCLES - 1)) |=> !busy);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .PCW         (PCW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .busy     (busy_w),
    .mem_we   (mem_we),
    .pcnt     (q.pcnt)
);

// File: tb/i2c_mem_slave_bench.sv
`timescale 1ns/1ps
module i2c_mem_slave_bench;
    localparam int PROG = 300;
    localparam int MSIZE = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       wc = 1'b0;
    logic       oe;
    logic       sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int mdl_mem [MSIZE];
    int mdl_addr = 0;

    assign sda_bus = m_sda & ~oe;

    always #2 clk = ~clk;

    i2c_mem_slave #(.DENSITY(2), .PROG_CYCLES(PROG)) u_i2c_mem_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .wc_i     (wc),
        .sda_oe_o (oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wt(4);
        scl = 1'b1;   wt(8);
        m_sda = 1'b0; wt(8);
        scl = 1'b0;   wt(4);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wt(4);
        scl = 1'b1;   wt(8);
        m_sda = 1'b1; wt(8);
    endtask

    task automatic send_bit(input bit b);
        m_sda = b;  wt(4);
        scl = 1'b1; wt(8);
        scl = 1'b0; wt(4);
    endtask

    task automatic recv_bit(output bit b);
        m_sda = 1'b1; wt(4);
        scl = 1'b1;   wt(4);
        b = sda_bus;  wt(4);
        scl = 1'b0;   wt(4);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        acked = (x == 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit give_ack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(!give_ack);
    endtask

    function automatic logic [7:0] sel(input bit rd, input int a);
        return {4'b1010, strap[2], strap[1], a[8], rd};
    endfunction

    // page write; model commits at STOP only when data was accepted
    task automatic wr_page(input int a, input int data[$], input bit wprot);
        bit ak;
        int pg;
        wc = wprot;
        do_start();
        send_byte(sel(0, a), ak);
        check(ak, "R4 write select ack", ak, 1);
        send_byte(a[7:0], ak);
        check(ak, "R4 address ack", ak, 1);
        mdl_addr = a;
        pg = a & ~15;
        foreach (data[k]) begin
            send_byte(data[k][7:0], ak);
            check(ak == !wprot, wprot ? "R5 protected data nack" : "R4 data ack", ak, !wprot);
            if (!wprot) begin
                mdl_mem[mdl_addr] = data[k] & 255;
                mdl_addr = pg | ((mdl_addr + 1) & 15);
            end
        end
        do_stop();
        wc = 1'b0;
    endtask

    task automatic rd_bytes(input int n, input string req);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k < n - 1);
            check(v == mdl_mem[mdl_addr][7:0], req, v, mdl_mem[mdl_addr]);
            mdl_addr = (mdl_addr + 1) % MSIZE;
        end
        do_stop();
    endtask

    task automatic rd_random(input int a, input int n, input string req);
        bit ak;
        do_start();
        send_byte(sel(0, a), ak);
        check(ak, "R8 dummy write select ack", ak, 1);
        send_byte(a[7:0], ak);
        check(ak, "R8 address ack", ak, 1);
        mdl_addr = a;
        do_start();
        send_byte(sel(1, a), ak);
        check(ak, "R8 read select ack", ak, 1);
        rd_bytes(n, req);
    endtask

    task automatic rd_current(input int n, input string req);
        bit ak;
        do_start();
        send_byte(sel(1, 0), ak);
        check(ak, "R9 read select ack", ak, 1);
        rd_bytes(n, req);
    endtask

    task automatic probe_busy(input bit exp_ack, input string req);
        bit ak;
        do_start();
        send_byte(sel(0, 0), ak);
        check(ak == exp_ack, req, ak, exp_ack);
        do_stop();
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected run end", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        bit ak;
        int q[$];
        for (int i = 0; i < MSIZE; i++) mdl_mem[i] = 0;
        wt(5);
        check(oe == 1'b0, "R11 SDA released in reset", oe, 0);
        rst_n = 1'b1;
        wt(10);
        check(oe == 1'b0, "R11 SDA released after reset", oe, 0);

        // R11, R9: counter 0, array zero
        rd_current(1, "R11 R9 current read after reset");

        // R1: wrong device type
        do_start();
        send_byte(8'hB0 | {6'b0, 1'b0, 1'b0}, ak);
        check(!ak, "R1 wrong type nack", ak, 0);
        do_stop();

        // R2: strap mismatch on b2 (compared with strap_i[1])
        do_start();
        send_byte({4'b1010, strap[2], ~strap[1], 1'b0, 1'b0}, ak);
        check(!ak, "R2 strap mismatch nack", ak, 0);
        do_stop();

        // R3: no START in front of the select byte
        wt(20);
        send_byte(sel(0, 0), ak);
        check(!ak, "R3 select without START ignored", ak, 0);
        do_stop();

        // byte write, then probe during programming
        q = '{8'hA5};
        wr_page(9'h005, q, 1'b0);
        probe_busy(1'b0, "R6 select ignored while programming");
        wt(PROG + 20);
        probe_busy(1'b1, "R6 select acked after programming");
        rd_random(9'h005, 1, "R8 random read of written byte");

        // R10: page write with wrap inside the page, A8 from select bit 1
        q = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr_page(9'h13E, q, 1'b0);
        wt(PROG + 20);
        rd_random(9'h130, 16, "R10 page wrap and untouched slots");

        // R10: seventeen bytes overwrite the first slot
        q = {};
        for (int k = 0; k < 17; k++) q.push_back(k + 1);
        wr_page(9'h040, q, 1'b0);
        wt(PROG + 20);
        rd_random(9'h040, 16, "R10 seventeenth byte overwrites slot");

        // R5: protected write, no programming started
        q = '{8'h5A};
        wr_page(9'h005, q, 1'b1);
        probe_busy(1'b1, "R5 no programming after protected write");
        rd_random(9'h005, 1, "R5 protected byte unchanged");

        // R7: sequential read wraps at end of array
        q = '{8'h5C};
        wr_page(9'h1FF, q, 1'b0);
        wt(PROG + 20);
        rd_random(9'h1FF, 2, "R7 sequential read wrap");

        // R9: current read continues from the counter
        rd_current(2, "R9 current read continues");

        // R7: after NoAck and STOP the line stays released
        wt(40);
        check(oe == 1'b0 && sda_bus == 1'b1, "R7 bus released after NoAck", oe, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule